// File: doc/BRIEF.md
# Keyed Adapter-Reset Guard

This block protects a host-triggered adapter reset from being fired by a stray write. The host has to write six specific values, in a fixed order, to a key register. Only then does the diagnostic register show its write-enable bit. While that bit is set, a write to the diagnostic register with the reset-request bit set produces a one-cycle adapter reset pulse. The same write locks the block again.

A wrong key value, written at any point, cancels all progress and takes back an enable that was already granted. Writes to any other offset leave the key progress unchanged. The host can read the diagnostic register at any time to see whether the block is unlocked.

Top module: `reset_key_guard`

## Requirements
- R1: Key-register writes (offset 0xF4) with the values 0x00, 0x04, 0x0B, 0x02, 0x07, 0x0D, in that order, unlock the block. A write that matches the next expected value advances progress by one step. When the sixth write matches, the diagnostic register takes the value 0x80, where bit 7 is the write-enable bit. Before that it stays 0x00.
- R2: A key-register write that does not equal the next expected value sets progress back to the start and clears the diagnostic register to 0x00. The mismatched write does not count as a first key value, even if it equals 0x00.
- R3: Writes to offsets other than 0xF4 and 0xF8 change neither the key progress nor the diagnostic register.
- R4: A read at offset 0xF8 returns the diagnostic register in the same cycle. A read at any other offset returns 0.
- R5: A write to offset 0xF8 with bit 2 set, made while bit 7 of the diagnostic register is set, raises reset_pulse_o for one cycle, starting at the clock edge that captures the write. The same edge clears both the diagnostic register and the key progress.
- R6: A write to offset 0xF8 while the block is locked, or a write there without bit 2 set, produces no pulse and leaves the diagnostic register unchanged.
- R7: Once all six key values have matched, a further key write of 0x0D keeps the unlock (0x80). Any other value written to the key register clears it.
- R8: A synchronous reset clears the key progress, the diagnostic register and reset_pulse_o.
- R9: reset_pulse_o is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Read data, combinational |
| reset_pulse_o | output | 1 | One-cycle adapter reset request |

## Verification
Two events can fall into the same cycle: the reset pulse that follows a firing write, and a key-register write that starts a new unlock. After the firing diagnostic write, the bench issues the first key value in the very next cycle. It then checks that the pulse is high in exactly that cycle, and that this write already counts as the first step of a fresh key. Finishing the key from there must give 0x80. A second case issues the firing write directly after the sixth key write, on consecutive cycles. Random mixes of key, diagnostic and stray writes are compared, write by write, against a bench model.

// File: rtl/rkg_pkg.sv
package rkg_pkg;
   // bit width of one key entry
   localparam int KEY_W   = 8;
   localparam int KEY_LEN = 6;
   // first entry in the lowest slot
   localparam logic [KEY_LEN-1:0][KEY_W-1:0] DEF_KEY =
      {8'h0D, 8'h07, 8'h02, 8'h0B, 8'h04, 8'h00};
endpackage

// File: rtl/rkg_key_tracker.sv
module rkg_key_tracker #(
   parameter int DATA_W  = 32,
   parameter int KEY_W   = 8,
   parameter int KEY_LEN = 6,
   parameter logic [KEY_LEN-1:0][KEY_W-1:0] KEY_VALUES = '0,
   localparam int POS_W  = $clog2(KEY_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              seq_wr,
   input  logic              clear,
   input  logic [DATA_W-1:0] wr_data,
   output logic              key_miss,
   output logic              key_reach
);
   localparam logic [POS_W-1:0] POS_FULL = POS_W'(KEY_LEN);
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(KEY_LEN - 1);

   logic [POS_W-1:0]   pos_q;
   logic [KEY_LEN-1:0] hit_vec;
   logic [POS_W-1:0]   sel;
   logic               hit;

   // one comparator per key slot
   for (genvar i = 0; i < KEY_LEN; i++) begin : g_cmp
      assign hit_vec[i] = (wr_data == DATA_W'(KEY_VALUES[i]));
   end

   // once complete, keep comparing against the final entry
   assign sel       = (pos_q >= POS_FULL) ? POS_LAST : pos_q;
   assign hit       = hit_vec[sel];
   assign key_miss  = seq_wr & ~hit;
   assign key_reach = seq_wr & hit & (pos_q >= POS_LAST);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         pos_q <= '0;
      end else if (seq_wr) begin
         if (!hit)
            pos_q <= '0;
         else if (pos_q < POS_FULL)
            pos_q <= pos_q + POS_W'(1);
      end
   end
endmodule

// File: rtl/rkg_diag_ctl.sv
module rkg_diag_ctl #(
   parameter int DATA_W  = 32,
   parameter int WEN_BIT = 7,
   parameter int RST_BIT = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              diag_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              key_miss,
   input  logic              key_reach,
   output logic [DATA_W-1:0] diag_q,
   output logic              fire,
   output logic              pulse_o
);
   localparam logic [DATA_W-1:0] WEN_VAL = DATA_W'(1) << WEN_BIT;

   if (WEN_BIT >= DATA_W || RST_BIT >= DATA_W || WEN_BIT == RST_BIT) begin : g_bad_bits
      $error("rkg_diag_ctl: control bit positions invalid");
   end

   assign fire = diag_wr & diag_q[WEN_BIT] & wr_data[RST_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         diag_q  <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= fire;
         if (fire || key_miss)
            diag_q <= '0;
         else if (key_reach)
            diag_q <= WEN_VAL;
      end
   end
endmodule

// File: rtl/reset_key_guard.sv
module reset_key_guard #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int KEY_W    = rkg_pkg::KEY_W,
   parameter int KEY_LEN  = rkg_pkg::KEY_LEN,
   parameter logic [KEY_LEN-1:0][KEY_W-1:0] KEY_VALUES = rkg_pkg::DEF_KEY,
   parameter logic [ADDR_W-1:0] SEQ_ADDR  = 8'hF4,
   parameter logic [ADDR_W-1:0] DIAG_ADDR = 8'hF8,
   parameter int WEN_BIT  = 7,
   parameter int RST_BIT  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              reset_pulse_o
);
   if (KEY_LEN < 1 || KEY_W > DATA_W || SEQ_ADDR == DIAG_ADDR) begin : g_bad_cfg
      $error("reset_key_guard: invalid configuration");
   end

   logic              seq_wr, diag_wr;
   logic              key_miss, key_reach, fire;
   logic [DATA_W-1:0] diag_q;

   assign seq_wr  = wr_en & (wr_addr == SEQ_ADDR);
   assign diag_wr = wr_en & (wr_addr == DIAG_ADDR);

   rkg_key_tracker #(
      .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LEN(KEY_LEN), .KEY_VALUES(KEY_VALUES)
   ) u_track (
      .clk(clk), .rst(rst), .seq_wr(seq_wr), .clear(fire), .wr_data(wr_data),
      .key_miss(key_miss), .key_reach(key_reach)
   );

   rkg_diag_ctl #(
      .DATA_W(DATA_W), .WEN_BIT(WEN_BIT), .RST_BIT(RST_BIT)
   ) u_diag (
      .clk(clk), .rst(rst), .diag_wr(diag_wr), .wr_data(wr_data),
      .key_miss(key_miss), .key_reach(key_reach),
      .diag_q(diag_q), .fire(fire), .pulse_o(reset_pulse_o)
   );

   assign rd_data = (rd_addr == DIAG_ADDR) ? diag_q : '0;
endmodule

// File: rtl/rkg_chk.sv
module rkg_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter logic [ADDR_W-1:0] SEQ_ADDR  = 8'hF4,
   parameter logic [ADDR_W-1:0] DIAG_ADDR = 8'hF8,
   parameter int WEN_BIT = 7,
   parameter int RST_BIT = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] diag_q,
   input logic              reset_pulse_o
);
   localparam logic [DATA_W-1:0] WEN_VAL = DATA_W'(1) << WEN_BIT;

   // R1
   diag_value_chk: assert property (@(posedge clk) disable iff (rst)
      (diag_q == '0) || (diag_q == WEN_VAL));

   // R3
   stray_write_chk: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_addr == SEQ_ADDR || wr_addr == DIAG_ADDR)) |=> $stable(diag_q));

   // R4
   read_other_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_addr != DIAG_ADDR) |-> (rd_data == '0));

   // R5
   fire_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == DIAG_ADDR && wr_data[RST_BIT] && diag_q[WEN_BIT])
      |=> (reset_pulse_o && diag_q == '0));

   // R6
   pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(reset_pulse_o) |-> $past(wr_en && wr_addr == DIAG_ADDR && diag_q[WEN_BIT]));

   // R8
   sync_reset_chk: assert property (@(posedge clk)
      rst |=> (diag_q == '0 && !reset_pulse_o));

   // R9
   single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      reset_pulse_o |=> !reset_pulse_o);
endmodule

bind reset_key_guard rkg_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_ADDR(SEQ_ADDR), .DIAG_ADDR(DIAG_ADDR),
   .WEN_BIT(WEN_BIT), .RST_BIT(RST_BIT)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_addr(rd_addr), .rd_data(rd_data), .diag_q(diag_q),
   .reset_pulse_o(reset_pulse_o)
);

// File: tb/sim_reset_key_guard.sv
`timescale 1ns/1ps
module sim_reset_key_guard;
   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [7:0]  wr_addr;
   logic [31:0] wr_data;
   logic [7:0]  rd_addr;
   logic [31:0] rd_data;
   logic        reset_pulse_o;

   int checks = 0;
   int errors = 0;
   int pos_m  = 0;
   logic [31:0] diag_m = 0;
   logic        pulse_m = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   reset_key_guard u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .reset_pulse_o(reset_pulse_o)
   );

   function automatic logic [31:0] key_at(int p);
      case (p)
         0: key_at = 32'h00;
         1: key_at = 32'h04;
         2: key_at = 32'h0B;
         3: key_at = 32'h02;
         4: key_at = 32'h07;
         default: key_at = 32'h0D;
      endcase
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // model update for one write (R1 R2 R3 R5 R6 R7)
   task automatic model(logic [7:0] a, logic [31:0] d);
      pulse_m = 0;
      if (a == 8'hF4) begin
         if (d == key_at(pos_m)) begin
            if (pos_m < 6) pos_m++;
            if (pos_m == 6) diag_m = 32'h80;
         end else begin
            pos_m = 0;
            diag_m = 0;
         end
      end else if (a == 8'hF8) begin
         if (diag_m[7] && d[2]) begin
            pulse_m = 1;
            pos_m = 0;
            diag_m = 0;
         end
      end
   endtask

   // caller is 1 ns past a rising edge; result checked 1 ns past the next
   task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 0;
      model(a, d);
      chk(reset_pulse_o === pulse_m, {tag, " pulse"}, 32'(reset_pulse_o), 32'(pulse_m));
      chk(rd_data === diag_m, {tag, " diag"}, rd_data, diag_m);
   endtask

   task automatic idle(string tag);
      @(posedge clk); #1;
      pulse_m = 0;
      chk(reset_pulse_o === 1'b0, {tag, " idle pulse"}, 32'(reset_pulse_o), 0);
   endtask

   task automatic full_key(string tag);
      for (int i = 0; i < 6; i++) wr(8'hF4, key_at(i), tag);
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 8'hF8;
      repeat (3) @(posedge clk);
      #1 rst = 0;
      // R8 reset state
      chk(rd_data === 0, "R8 diag after reset", rd_data, 0);
      chk(reset_pulse_o === 0, "R8 pulse after reset", 32'(reset_pulse_o), 0);

      // R1 full key unlocks
      full_key("R1");
      // R4 other read offset
      rd_addr = 8'hF0; #0.5;
      chk(rd_data === 0, "R4 other offset", rd_data, 0);
      rd_addr = 8'hF8; #0.5;
      chk(rd_data === 32'h80, "R4 diag offset", rd_data, 32'h80);
      // R3 stray writes keep unlock
      wr(8'hF0, 32'h0000_0004, "R3");
      wr(8'h00, 32'hFFFF_FFFF, "R3");
      // R6 diag write without bit 2
      wr(8'hF8, 32'h0000_00FB, "R6");
      // R7 repeated last key keeps unlock
      wr(8'hF4, 32'h0D, "R7");
      // R5 fire, then key start in the pulse cycle
      wr(8'hF8, 32'h4, "R5");
      wr(8'hF4, 32'h00, "R5 pulse-cycle key");
      idle("R9");
      for (int i = 1; i < 6; i++) wr(8'hF4, key_at(i), "R5 resumed key");
      chk(rd_data === 32'h80, "R5 resumed unlock", rd_data, 32'h80);
      // R7 other value after unlock clears
      wr(8'hF4, 32'h04, "R7 clear");
      // R6 fire attempt while locked
      wr(8'hF8, 32'hFFFF_FFFF, "R6 locked");
      idle("R6");
      // R2 mismatch not recounted as start
      wr(8'hF4, 32'h00, "R2");
      wr(8'hF4, 32'h00, "R2 mismatch");
      for (int i = 1; i < 6; i++) wr(8'hF4, key_at(i), "R2 after miss");
      chk(rd_data === 0, "R2 still locked", rd_data, 0);
      // R3 stray write mid-key keeps progress
      wr(8'hF4, 32'h00, "R3"); wr(8'hF4, 32'h04, "R3");
      wr(8'h10, 32'h0B, "R3 stray");
      for (int i = 2; i < 6; i++) wr(8'hF4, key_at(i), "R3 progress");
      // R5 fire directly after sixth key write
      wr(8'hF8, 32'h4, "R5 back-to-back");
      idle("R9");
      // R8 reset mid-key
      wr(8'hF4, 32'h00, "R8"); wr(8'hF4, 32'h04, "R8");
      rst = 1; @(posedge clk); #1 rst = 0;
      pos_m = 0; diag_m = 0; pulse_m = 0;
      chk(rd_data === 0, "R8 sync reset", rd_data, 0);
      for (int i = 2; i < 6; i++) wr(8'hF4, key_at(i), "R8 progress lost");
      chk(rd_data === 0, "R8 no unlock", rd_data, 0);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom_range(0, 99);
         logic [7:0]  a;
         logic [31:0] d;
         if (r < 60) begin
            a = 8'hF4;
            d = ($urandom_range(0, 9) < 8) ? key_at(pos_m) : 32'($urandom_range(0, 15));
         end else if (r < 80) begin
            a = 8'hF8;
            d = $urandom;
         end else begin
            a = 8'($urandom_range(0, 239));
            d = $urandom;
         end
         wr(a, d, "R1/R2/R5/R6/R7 random");
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule